// File: doc/BRIEF.md
# Ethernet Frame Splitter with Delimiter and Check-Sequence Gate

This block sits between a receive buffer and a header parser. It takes raw Ethernet frames one byte per clock, each frame closed by an end marker. It looks for the run of preamble bytes and the start-of-frame delimiter, then stores the frame body in an internal frame store. While the bytes arrive it runs the CRC-32 and counts the length.

Nothing leaves the block until the end marker of a frame has been accepted. A frame can fail because its delimiter is wrong, its check sequence is wrong, it is too short, or it does not fit the frame store. Such a frame is dropped whole, and the block reports it with a single done pulse while its valid flag stays low. A frame that passes is read back out of the store. Its fourteen address and type bytes go to a header-field port, each tagged with its position. The bytes after them go to a payload port, with the check sequence left out. Trailing pad is also left out when the type marks an IPv4 packet. A done pulse, paired with a valid pulse, closes each passing frame.

While a frame is being checked and read out, the block holds its ready output low. The buffer in front must hold back further bytes until ready is high again.

Top module: `eth_frame_splitter`

## Requirements
- R1: The bytes before the delimiter and the delimiter byte itself never appear on any output. The header port carries exactly the first 14 bytes after the delimiter, with hdr_index counting 0 to 13. Those positions hold destination address 0-5, source address 6-11 and type 12-13.
- R2: Preamble bytes have the value 0x55 and may be absent. The first byte that is not 0x55 must be 0xD5. If it is any other value, the frame produces no header or payload output, and its done pulse comes with frame_ok low.
- R3: The check sequence is the last four bytes before the end marker. It is a CRC-32 with polynomial 0x04C11DB7, bit-reflected, initial value 0xFFFFFFFF, and sent low byte first. Running the CRC over the body plus these four bytes must leave 0xC704DD7B when the register is read in polynomial bit order. A failing frame produces no output and frame_ok stays low. The check-sequence bytes are never output.
- R4: For a frame whose type field (bytes 12-13, big-endian) is not 0x0800, the payload port carries every byte from position 14 up to the check sequence, in order.
- R5: For type 0x0800, the IPv4 total length is read from positions 16-17, big-endian. If it is smaller than the number of bytes between the header and the check sequence, only that many payload bytes are output. Otherwise all of those bytes are output.
- R6: A frame with fewer than MIN_BYTES (default 64) bytes from the first address byte through the last check-sequence byte is invalid. It produces no output and frame_ok stays low.
- R7: A frame with more than MAX_BYTES (default 256) bytes in that span is invalid. It produces no output and frame_ok stays low.
- R8: frame_done is a one-cycle pulse, issued exactly once per frame and only after that frame's last header or payload byte. frame_ok is high only in a cycle where frame_done is high.
- R9: No output byte of a frame appears before its end marker has been accepted. in_ready drops in the cycle after the end marker is accepted and stays low until after frame_done. Input bytes offered while in_ready is low are ignored.
- R10: After reset, in_ready is high and all output strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | High when input bytes are accepted |
| hdr_valid | output | 1 | Header-field byte strobe |
| hdr_index | output | 4 | Position of the header byte, 0 to 13 |
| hdr_data | output | 8 | Header-field byte |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| frame_done | output | 1 | End-of-extraction pulse, one per frame |
| frame_ok | output | 1 | Valid pulse, together with frame_done for a passing frame |

## Verification
The stimulus includes frames of several kinds:

- Good non-IPv4 frames at the minimum length and near the store limit. These separate plain payload steering from length limits.
- A frame one byte short and a frame one byte over the store limit. These show the limit comparisons are exact.
- IPv4 frames whose total length is below, equal to and above the available payload. These show whether pad is trimmed only when it exists.
- A wrong delimiter and a corrupted check sequence. These show that both gates drop the whole frame instead of passing part of it.
- Different preamble lengths, including none. These show that delimiter search does not depend on a fixed preamble count.

A directed run offers delimiter-valued bytes while in_ready is low. It then sends another good frame, to show that such bytes are ignored and leave no state behind.

// File: rtl/eth_split_pkg.sv
package eth_split_pkg;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam int          HDR_LEN    = 14;
  localparam int          FCS_LEN    = 4;
  localparam logic [15:0] TYPE_IPV4  = 16'h0800;
  localparam logic [31:0] CRC_INIT   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
  localparam logic [31:0] CRC_GOOD   = 32'hC704_DD7B;

  typedef enum logic [1:0] {
    C_PRE  = 2'd0,
    C_BODY = 2'd1,
    C_SKIP = 2'd2,
    C_HOLD = 2'd3
  } cap_state_t;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_frame_ram.sv
module eth_frame_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/eth_frame_capture.sv
module eth_frame_capture
  import eth_split_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  parameter int MIN_BYTES = 64,
  localparam int AW = $clog2(MAX_BYTES),
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          release_i,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          res_valid,
  output logic          res_good,
  output logic [CW-1:0] res_n,
  output logic          res_ip,
  output logic [15:0]   res_iplen
);

  cap_state_t  st;
  logic [31:0] crc, crc_nx, crc_rev;
  logic [CW-1:0] cnt, cnt_nx;
  logic        ovf, ovf_nx;
  logic [7:0]  et_hi, et_lo, ip_hi;
  logic        accept, at_cap, good_nx;

  assign in_ready = (st != C_HOLD);
  assign accept   = in_valid && in_ready;
  assign at_cap   = (cnt == CW'(MAX_BYTES));

  always_comb begin
    crc_nx  = crc32_byte(crc, in_data);
    crc_rev = {<<{crc_nx}};
    cnt_nx  = at_cap ? cnt : cnt + CW'(1);
    ovf_nx  = ovf | at_cap;
    good_nx = !ovf_nx && (crc_rev == CRC_GOOD) && (cnt_nx >= CW'(MIN_BYTES));
  end

  assign wr_en   = accept && (st == C_BODY) && !at_cap;
  assign wr_addr = cnt[AW-1:0];
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_PRE;
      crc       <= CRC_INIT;
      cnt       <= '0;
      ovf       <= 1'b0;
      et_hi     <= '0;
      et_lo     <= '0;
      ip_hi     <= '0;
      res_valid <= 1'b0;
      res_good  <= 1'b0;
      res_n     <= '0;
      res_ip    <= 1'b0;
      res_iplen <= '0;
    end else begin
      res_valid <= 1'b0;
      if (st == C_HOLD) begin
        if (release_i) st <= C_PRE;
      end else if (accept) begin
        unique case (st)
          C_PRE: begin
            crc   <= CRC_INIT;
            cnt   <= '0;
            ovf   <= 1'b0;
            et_hi <= '0;
            et_lo <= '0;
            if (in_last) begin
              st        <= C_HOLD;
              res_valid <= 1'b1;
              res_good  <= 1'b0;
            end else if (in_data == SFD_BYTE) begin
              st <= C_BODY;
            end else if (in_data != PRE_BYTE) begin
              st <= C_SKIP;
            end
          end
          C_BODY: begin
            crc <= crc_nx;
            cnt <= cnt_nx;
            ovf <= ovf_nx;
            if (cnt == CW'(12)) et_hi <= in_data;
            if (cnt == CW'(13)) et_lo <= in_data;
            if (cnt == CW'(16)) ip_hi <= in_data;
            if (cnt == CW'(17)) res_iplen <= {ip_hi, in_data};
            if (in_last) begin
              st        <= C_HOLD;
              res_valid <= 1'b1;
              res_good  <= good_nx;
              res_n     <= cnt_nx;
              res_ip    <= ({et_hi, et_lo} == TYPE_IPV4);
            end
          end
          C_SKIP: begin
            if (in_last) begin
              st        <= C_HOLD;
              res_valid <= 1'b1;
              res_good  <= 1'b0;
            end
          end
          default: st <= C_PRE;
        endcase
      end
    end
  end

endmodule

// File: rtl/eth_frame_drain.sv
module eth_frame_drain
  import eth_split_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  localparam int AW = $clog2(MAX_BYTES),
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] end_cnt,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          hdr_valid,
  output logic [3:0]    hdr_index,
  output logic [7:0]    hdr_data,
  output logic          pay_valid,
  output logic [7:0]    pay_data,
  output logic          fin
);

  logic          running;
  logic [CW-1:0] ra, endr;
  logic          v1, hdr1, last1, lastq;
  logic [3:0]    idx1;
  logic          is_end;

  assign is_end  = (ra == endr - CW'(1));
  assign rd_en   = running;
  assign rd_addr = ra[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      ra        <= '0;
      endr      <= '0;
      v1        <= 1'b0;
      hdr1      <= 1'b0;
      last1     <= 1'b0;
      idx1      <= '0;
      lastq     <= 1'b0;
      hdr_valid <= 1'b0;
      hdr_index <= '0;
      hdr_data  <= '0;
      pay_valid <= 1'b0;
      pay_data  <= '0;
      fin       <= 1'b0;
    end else begin
      v1    <= running;
      hdr1  <= (ra < CW'(HDR_LEN));
      idx1  <= ra[3:0];
      last1 <= running && is_end;
      if (start) begin
        running <= 1'b1;
        ra      <= '0;
        endr    <= end_cnt;
      end else if (running) begin
        ra <= ra + CW'(1);
        if (is_end) running <= 1'b0;
      end
      hdr_valid <= v1 && hdr1;
      pay_valid <= v1 && !hdr1;
      hdr_index <= idx1;
      hdr_data  <= rd_data;
      pay_data  <= rd_data;
      lastq     <= v1 && last1;
      fin       <= lastq;
    end
  end

endmodule

// File: rtl/eth_frame_splitter.sv
module eth_frame_splitter
  import eth_split_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  parameter int MIN_BYTES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       hdr_valid,
  output logic [3:0] hdr_index,
  output logic [7:0] hdr_data,
  output logic       pay_valid,
  output logic [7:0] pay_data,
  output logic       frame_done,
  output logic       frame_ok
);

  localparam int AW = $clog2(MAX_BYTES);
  localparam int CW = $clog2(MAX_BYTES + 1);

  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;
  logic          res_valid, res_good, res_ip;
  logic [CW-1:0] res_n;
  logic [15:0]   res_iplen;
  logic          drain_fin;
  logic [CW-1:0] body_raw, body, end_cnt;

  always_comb begin
    body_raw = res_n - CW'(HDR_LEN + FCS_LEN);
    body     = body_raw;
    if (res_ip && ({1'b0, res_iplen} < 17'(body_raw))) body = CW'(res_iplen);
    end_cnt  = body + CW'(HDR_LEN);
  end

  eth_frame_capture #(.MAX_BYTES(MAX_BYTES), .MIN_BYTES(MIN_BYTES)) i_cap (
    .clk, .rst, .in_valid, .in_data, .in_last, .in_ready,
    .release_i(frame_done),
    .wr_en, .wr_addr, .wr_data,
    .res_valid, .res_good, .res_n, .res_ip, .res_iplen
  );

  eth_frame_ram #(.DEPTH(MAX_BYTES), .WIDTH(8)) i_ram (
    .clk, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .rd_data
  );

  eth_frame_drain #(.MAX_BYTES(MAX_BYTES)) i_drain (
    .clk, .rst,
    .start(res_valid && res_good), .end_cnt,
    .rd_en, .rd_addr, .rd_data,
    .hdr_valid, .hdr_index, .hdr_data, .pay_valid, .pay_data,
    .fin(drain_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
    end else begin
      frame_done <= drain_fin || (res_valid && !res_good);
      frame_ok   <= drain_fin;
    end
  end

endmodule

module eth_split_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_last,
  input logic       in_ready,
  input logic       hdr_valid,
  input logic [3:0] hdr_index,
  input logic       pay_valid,
  input logic       frame_done,
  input logic       frame_ok
);

  // R8
  ok_with_done_chk: assert property (@(posedge clk) disable iff (rst) frame_ok |-> frame_done);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst) frame_done |=> !frame_done);

  // R9
  quiet_input_chk: assert property (@(posedge clk) disable iff (rst) (hdr_valid || pay_valid) |-> !in_ready);

  // R9
  hold_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R1
  one_port_chk: assert property (@(posedge clk) disable iff (rst) !(hdr_valid && pay_valid));

  // R1
  hdr_order_chk: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && $past(hdr_valid)) |-> (hdr_index == $past(hdr_index) + 4'd1));

  // R1
  hdr_range_chk: assert property (@(posedge clk) disable iff (rst) hdr_valid |-> (hdr_index <= 4'd13));

endmodule

bind eth_frame_splitter eth_split_chk i_chk (
  .clk, .rst, .in_valid, .in_last, .in_ready, .hdr_valid, .hdr_index,
  .pay_valid, .frame_done, .frame_ok
);

// File: tb/test_eth_frame_splitter.sv
module test_eth_frame_splitter;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_last;
  logic [7:0] in_data;
  logic       in_ready, hdr_valid, pay_valid, frame_done, frame_ok;
  logic [3:0] hdr_index;
  logic [7:0] hdr_data, pay_data;

  always #2.5 clk = ~clk;

  eth_frame_splitter i_eth_frame_splitter (
    .clk, .rst, .in_valid, .in_data, .in_last, .in_ready,
    .hdr_valid, .hdr_index, .hdr_data, .pay_valid, .pay_data,
    .frame_done, .frame_ok
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct packed {
    logic [1:0]  kind;  // 0 good, 1 wrong delimiter, 2 corrupt check sequence
    logic [3:0]  pre;
    logic [8:0]  plen;
    logic        ip;
    logic [15:0] tot;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{kind: 2'd0, pre: 4'd7,  plen: 9'd46,  ip: 1'b0, tot: 16'd0},
    '{kind: 2'd0, pre: 4'd7,  plen: 9'd45,  ip: 1'b0, tot: 16'd0},
    '{kind: 2'd0, pre: 4'd3,  plen: 9'd46,  ip: 1'b1, tot: 16'd28},
    '{kind: 2'd0, pre: 4'd7,  plen: 9'd100, ip: 1'b1, tot: 16'd100},
    '{kind: 2'd0, pre: 4'd7,  plen: 9'd60,  ip: 1'b1, tot: 16'd200},
    '{kind: 2'd1, pre: 4'd7,  plen: 9'd50,  ip: 1'b0, tot: 16'd0},
    '{kind: 2'd2, pre: 4'd7,  plen: 9'd50,  ip: 1'b0, tot: 16'd0},
    '{kind: 2'd0, pre: 4'd0,  plen: 9'd238, ip: 1'b0, tot: 16'd0},
    '{kind: 2'd0, pre: 4'd7,  plen: 9'd239, ip: 1'b0, tot: 16'd0},
    '{kind: 2'd2, pre: 4'd15, plen: 9'd60,  ip: 1'b1, tot: 16'd30},
    '{kind: 2'd0, pre: 4'd1,  plen: 9'd80,  ip: 1'b0, tot: 16'd0}
  };

  logic [7:0] fr [0:299];
  int         fr_len;
  logic [7:0] got_hdr [0:15];
  logic [7:0] got_pay [0:299];
  int         hdr_cnt, pay_cnt, done_cnt, late_cnt, hdr_pos_err;
  logic       ok_seen;

  always @(negedge clk) begin
    if (hdr_valid) begin
      if (done_cnt > 0) late_cnt++;
      if (hdr_index != 4'(hdr_cnt)) hdr_pos_err++;
      got_hdr[hdr_index] = hdr_data;
      hdr_cnt++;
    end
    if (pay_valid) begin
      if (done_cnt > 0) late_cnt++;
      if (pay_cnt < 300) got_pay[pay_cnt] = pay_data;
      pay_cnt++;
    end
    if (frame_done) begin
      done_cnt++;
      ok_seen = frame_ok;
    end else if (frame_ok) begin
      late_cnt++;
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic build(input vec_t v, input int seed);
    int p = 0;
    int body_start;
    logic [31:0] c;
    for (int i = 0; i < v.pre; i++) fr[p++] = 8'h55;
    fr[p++] = (v.kind == 2'd1) ? 8'hD7 : 8'hD5;
    body_start = p;
    for (int i = 0; i < 6; i++) fr[p++] = 8'(8'h10 + i + seed);
    for (int i = 0; i < 6; i++) fr[p++] = 8'(8'h20 + i + seed);
    fr[p++] = v.ip ? 8'h08 : 8'h88;
    fr[p++] = v.ip ? 8'h00 : 8'hB5;
    for (int i = 0; i < v.plen; i++) fr[p++] = 8'(i * 7 + seed * 3 + 1);
    if (v.ip) begin
      fr[body_start + 14] = 8'h45;
      fr[body_start + 15] = 8'h00;
      fr[body_start + 16] = v.tot[15:8];
      fr[body_start + 17] = v.tot[7:0];
    end
    c = 32'hFFFFFFFF;
    for (int i = body_start; i < p; i++) c = crc_step(c, fr[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) fr[p++] = c[8*i +: 8];
    if (v.kind == 2'd2) fr[p-2] = fr[p-2] ^ 8'h04;
    fr_len = p;
  endtask

  task automatic run_frame(input vec_t v, input int seed, input bit junk, input string tag);
    int  n;
    bit  exp_ok;
    int  exp_pay;
    int  hs;
    int  mism;
    build(v, seed);
    n = 18 + int'(v.plen);
    exp_ok = (v.kind == 2'd0) && (n >= 64) && (n <= 256);
    exp_pay = 0;
    if (exp_ok) exp_pay = (v.ip && int'(v.tot) < int'(v.plen)) ? int'(v.tot) : int'(v.plen);
    hs = int'(v.pre) + 1;
    hdr_cnt = 0; pay_cnt = 0; done_cnt = 0; late_cnt = 0; hdr_pos_err = 0; ok_seen = 0;
    for (int i = 0; i < fr_len; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == fr_len - 1);
    end
    @(negedge clk);
    check(in_ready == 1'b0, {tag, " R9 ready low after end marker"}, int'(in_ready), 0);
    check(hdr_cnt == 0 && pay_cnt == 0, {tag, " R9 no output before end marker"}, hdr_cnt + pay_cnt, 0);
    in_last = 1'b0;
    if (junk) begin
      in_data = 8'hD5;
    end else begin
      in_valid = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(ok_seen == exp_ok, {tag, " R2 R3 R6 R7 frame_ok"}, int'(ok_seen), int'(exp_ok));
    check(hdr_cnt == (exp_ok ? 14 : 0) && hdr_pos_err == 0, {tag, " R1 header count"}, hdr_cnt, exp_ok ? 14 : 0);
    mism = 0;
    if (exp_ok) for (int i = 0; i < 14; i++) if (got_hdr[i] !== fr[hs + i]) mism++;
    check(mism == 0, {tag, " R1 header bytes"}, mism, 0);
    check(pay_cnt == exp_pay, {tag, " R4 R5 payload count"}, pay_cnt, exp_pay);
    mism = 0;
    for (int i = 0; i < exp_pay && i < pay_cnt; i++) if (got_pay[i] !== fr[hs + 14 + i]) mism++;
    check(mism == 0, {tag, " R4 R5 payload bytes"}, mism, 0);
    check(done_cnt == 1 && late_cnt == 0, {tag, " R8 done pulse"}, done_cnt * 100 + late_cnt, 100);
  endtask

  initial begin
    in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
    check({hdr_valid, pay_valid, frame_done, frame_ok} == 4'b0, "R10 strobes after reset",
          int'({hdr_valid, pay_valid, frame_done, frame_ok}), 0);
    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i], i, 1'b0, $sformatf("vec%0d", i));
    end
    // R9 bytes offered while in_ready is low are ignored
    run_frame(VEC[3], 20, 1'b1, "junk_a R9");
    run_frame(VEC[0], 21, 1'b0, "junk_b R9");
    // R2 delimiter error followed at once by a good frame
    run_frame(VEC[5], 22, 1'b0, "sfd_a R2");
    run_frame(VEC[2], 23, 1'b0, "sfd_b R2");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule